// File: doc/BRIEF.md
# Dual-Port Two-Beat Burst SRAM

This block is a synchronous static memory with one read port and one write port, both working at the same time. Each port takes one request per base cycle. A request names a burst address and moves two consecutive words. The double-data-rate behaviour is modelled with one fast clock `clk` that runs at twice the base rate. The block generates an alternating phase indicator `beat_ph` from that clock:
- When `beat_ph` is 0, the next `clk` edge is the base-cycle rising edge. At that edge the selects, the addresses and the first write beat are sampled.
- When `beat_ph` is 1, the next edge is the complementary edge, which takes the second write beat.

A read returns its two words one and a half base cycles after the request. That is the third and fourth fast edges after the request edge, and the two words come back to back. Write data can be masked byte by byte, and the mask is sampled separately on each beat. A read that starts in the same cycle as a write to the same burst sees the new data. An idle read port drives zero with the valid flag low, which models the high-impedance output.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `rd_valid` is 0, `rd_data` is all zeros and `beat_ph` is 0.
- R2: After reset `beat_ph` toggles on every `clk` edge, so it is 1 after an odd number of edges since release and 0 after an even number.
- R3: A low `rd_sel_n` sampled on an edge where `beat_ph` was 0 starts a read of burst address A. The first word returned is internal word {A,0} and the second is {A,1}: the burst base is two-word aligned and the second word sets the least significant bit.
- R4: For a read request on edge n, `rd_data` holds word {A,0} with `rd_valid` high after edge n+3, and holds word {A,1} with `rd_valid` high after edge n+4.
- R5: A low `wr_sel_n` sampled on an edge where `beat_ph` was 0 writes `wr_data` taken at that edge into word {A,0}. It writes `wr_data` taken at the next edge into word {A,1}.
- R6: On each write beat, a high bit b of `wr_be_n` leaves byte b of the target word (bits 8b+7 down to 8b) unchanged. The mask is sampled per beat, so the two beats may use different masks.
- R7: When a select is high on an edge where `beat_ph` was 0, that port does nothing: no word is written and no read beat is produced. Selects, addresses and data presented on the second phase of a cycle do not start requests.
- R8: A read returns the array contents after every write whose request edge is at or before the read's request edge, including a write to the same burst in the same cycle. It does not see writes started in later cycles.
- R9: Reads requested on consecutive base cycles produce an unbroken stream of valid beats with no idle sample between bursts.
- R10: Whenever `rd_valid` is low, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the base rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled when `beat_ph` is 0 |
| rd_addr | input | BAW (4) | Read burst address |
| wr_sel_n | input | 1 | Active-low write request, sampled when `beat_ph` is 0 |
| wr_addr | input | BAW (4) | Write burst address |
| wr_data | input | NBYTES*8 (32) | Write data, one beat per fast edge |
| wr_be_n | input | NBYTES (4) | Active-low byte write enables, one per beat |
| beat_ph | output | 1 | Phase indicator: 0 means the next edge is the base-cycle edge |
| rd_valid | output | 1 | Read beat present on `rd_data` |
| rd_data | output | NBYTES*8 (32) | Read data beat, zero when not valid |

## Verification
The assertions check the timing skeleton on every cycle:
- strict phase alternation;
- valid beats arriving exactly three and four edges after each read request, and never after an idle request;
- a burst always starting on the first phase with its second word following;
- zero data whenever valid is low;
- array writes occurring only on a requested beat pair.

What the assertions cannot show is the data content. Correct byte masking with masks that differ between beats, burst word ordering, and the visibility boundary between same-cycle and next-cycle writes are shown only by the bench's scenarios, against its own reference memory.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BYTE_W = 8;

  // Position within one base cycle, seen as the edge that comes next.
  typedef enum logic {
    PH_K  = 1'b0,  // next edge is the base-cycle edge
    PH_KB = 1'b1   // next edge is the complementary edge
  } phase_e;
endpackage

// File: rtl/qdr_phase_gen.sv
module qdr_phase_gen (
  input  logic            clk,
  input  logic            rst_n,
  output qdr_pkg::phase_e ph
);
  import qdr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_K;
    else        ph <= (ph == PH_K) ? PH_KB : PH_K;
  end
endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port #(
  parameter int BAW = 4,
  parameter int NB  = 4,
  localparam int DW  = NB * qdr_pkg::BYTE_W,
  localparam int WAW = BAW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  qdr_pkg::phase_e ph,
  input  logic            wr_sel_n,
  input  logic [BAW-1:0]  wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NB-1:0]   wr_be_n,
  output logic            we,
  output logic [WAW-1:0]  waddr,
  output logic [DW-1:0]   wdata,
  output logic [NB-1:0]   wbe_n,
  output logic            beat0_we,
  output logic            beat1_we
);
  import qdr_pkg::*;

  // Internal word address of a beat inside an aligned two-word burst.
  function automatic logic [WAW-1:0] beat_addr(input logic [BAW-1:0] base,
                                               input logic beat);
    return {base, beat};
  endfunction

  logic           pend;
  logic [BAW-1:0] base;
  logic           k_edge;

  assign k_edge   = (ph == PH_K);
  assign beat0_we = k_edge && !wr_sel_n;
  assign beat1_we = !k_edge && pend;
  assign we       = beat0_we || beat1_we;
  assign waddr    = k_edge ? beat_addr(wr_addr, 1'b0) : beat_addr(base, 1'b1);
  assign wdata    = wr_data;
  assign wbe_n    = wr_be_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      base <= '0;
    end else if (k_edge) begin
      pend <= !wr_sel_n;
      if (!wr_sel_n) base <= wr_addr;
    end else begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int BAW = 4,
  parameter int NB  = 4,
  localparam int DW    = NB * qdr_pkg::BYTE_W,
  localparam int WAW   = BAW + 1,
  localparam int DEPTH = 1 << WAW
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WAW-1:0]     waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [NB-1:0]      wbe_n,
  input  logic [BAW-1:0]     rbase,
  output logic [1:0][DW-1:0] rword
);
  import qdr_pkg::*;

  logic [DW-1:0] mem [DEPTH];

  // Keep a byte of the old word wherever its active-low enable is high.
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] keep_n);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b*BYTE_W +: BYTE_W] = keep_n[b] ? old_w[b*BYTE_W +: BYTE_W]
                                        : new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wbe_n);
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rword[p] = mem[{rbase, 1'(p)}];
  end
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
  parameter int BAW = 4,
  parameter int NB  = 4,
  localparam int DW = NB * qdr_pkg::BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  qdr_pkg::phase_e    ph,
  input  logic               rd_sel_n,
  input  logic [BAW-1:0]     rd_addr,
  input  logic [1:0][DW-1:0] rword,
  output logic [BAW-1:0]     rbase,
  output logic               req_acc,
  output logic               snap_ld,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data
);
  import qdr_pkg::*;

  logic               rq_pend;
  logic [BAW-1:0]     rq_base;
  logic               out_pend;
  logic [1:0][DW-1:0] hold;
  logic               k_edge;

  assign k_edge  = (ph == PH_K);
  assign rbase   = rq_base;
  assign req_acc = k_edge && !rd_sel_n;
  assign snap_ld = k_edge && rq_pend;

  // Stage 1 (base edge): capture request. Stage 2 (next base edge): copy both
  // words out of the array. Stage 3/4 (following two edges): present beats.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_pend  <= 1'b0;
      rq_base  <= '0;
      out_pend <= 1'b0;
      hold     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (k_edge) begin
      rq_pend  <= !rd_sel_n;
      if (!rd_sel_n) rq_base <= rd_addr;
      out_pend <= rq_pend;
      if (rq_pend) hold <= rword;
      rd_valid <= out_pend;
      rd_data  <= out_pend ? hold[1] : '0;
    end else begin
      rd_valid <= out_pend;
      rd_data  <= out_pend ? hold[0] : '0;
    end
  end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int BAW    = 4,
  parameter int NBYTES = 4,
  localparam int DW  = NBYTES * qdr_pkg::BYTE_W,
  localparam int WAW = BAW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic [BAW-1:0]    rd_addr,
  input  logic              wr_sel_n,
  input  logic [BAW-1:0]    wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NBYTES-1:0] wr_be_n,
  output logic              beat_ph,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  qdr_pkg::phase_e    ph;
  logic               mem_we;
  logic [WAW-1:0]     mem_waddr;
  logic [DW-1:0]      mem_wdata;
  logic [NBYTES-1:0]  mem_wbe_n;
  logic               beat0_we;
  logic               beat1_we;
  logic [BAW-1:0]     rd_base;
  logic [1:0][DW-1:0] rd_words;
  logic               rd_req_acc;
  logic               rd_snap_ld;

  assign beat_ph = ph;

  qdr_phase_gen u_ph (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph)
  );

  qdr_wr_port #(.BAW(BAW), .NB(NBYTES)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .wr_sel_n (wr_sel_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be_n  (wr_be_n),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .wbe_n    (mem_wbe_n),
    .beat0_we (beat0_we),
    .beat1_we (beat1_we)
  );

  qdr_array #(.BAW(BAW), .NB(NBYTES)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .wbe_n (mem_wbe_n),
    .rbase (rd_base),
    .rword (rd_words)
  );

  qdr_rd_pipe #(.BAW(BAW), .NB(NBYTES)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .rd_sel_n (rd_sel_n),
    .rd_addr  (rd_addr),
    .rword    (rd_words),
    .rbase    (rd_base),
    .req_acc  (rd_req_acc),
    .snap_ld  (rd_snap_ld),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_ph,
  input logic          rd_sel_n,
  input logic          wr_sel_n,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          mem_we,
  input logic          beat0_we,
  input logic          beat1_we,
  input logic          rd_req_acc
);
  always @(negedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!rd_valid && rd_data == '0 && !beat_ph); // R1
  end

  AST_PHASE_ALT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ph |=> beat_ph); // R2
  AST_PHASE_ALT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ph |=> !beat_ph); // R2
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_acc |-> ##4 rd_valid ##1 rd_valid); // R4
  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_ph && rd_sel_n) |-> ##4 !rd_valid ##1 !rd_valid); // R7
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0); // R10
  AST_WR_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((!beat_ph && !wr_sel_n) || (beat_ph && $past(!beat_ph && !wr_sel_n)))); // R7
  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    beat1_we |-> $past(beat0_we)); // R5
  AST_BURST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && beat_ph) |-> $past(rd_valid)); // R3
  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !beat_ph); // R3
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat_ph    (beat_ph),
  .rd_sel_n   (rd_sel_n),
  .wr_sel_n   (wr_sel_n),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .mem_we     (mem_we),
  .beat0_we   (beat0_we),
  .beat1_we   (beat1_we),
  .rd_req_acc (rd_req_acc)
);

// File: tb/sim_qdr_burst_sram.sv
`timescale 1ns/1ps
module sim_qdr_burst_sram;
  localparam int BAW = 4;
  localparam int NB  = 4;
  localparam int DW  = NB * 8;
  localparam int NW  = 1 << (BAW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic [BAW-1:0] rd_addr = '0;
  logic          wr_sel_n = 1'b1;
  logic [BAW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be_n = '1;
  logic          beat_ph;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int fc = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [NW];
  logic          exp_v [16];
  logic [DW-1:0] exp_d [16];
  string         exp_tag [16];

  always #5 clk = ~clk;

  qdr_burst_sram #(.BAW(BAW), .NBYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .beat_ph(beat_ph), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Per-bit rebuild of a masked write: bit i follows enable i/8.
  function automatic logic [DW-1:0] masked(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [NB-1:0] en_n);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = en_n[i / 8] ? old_w[i] : new_w[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) fc <= fc + 1;

  // Scoreboard: every sample after reset is compared with the expected slot.
  always @(negedge clk) begin
    if (rst_n && running) begin
      check("R2", DW'(beat_ph), DW'(fc[0]));
      if (exp_v[fc % 16]) begin
        check({exp_tag[fc % 16], " valid"}, DW'(rd_valid), DW'(1));
        check(exp_tag[fc % 16], rd_data, exp_d[fc % 16]);
      end else begin
        check("R10 valid", DW'(rd_valid), DW'(0));
        check("R10", rd_data, '0);
      end
      exp_v[fc % 16] = 1'b0;
      exp_d[fc % 16] = '0;
    end
  end

  // One base cycle: entered at a negedge with beat_ph==0, leaves at the next.
  task automatic cyc(input logic rs_n, input logic [BAW-1:0] ra,
                     input logic ws_n, input logic [BAW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [NB-1:0] b0,
                     input logic [DW-1:0] d1, input logic [NB-1:0] b1,
                     input string tag);
    int c;
    c = fc;
    rd_sel_n = rs_n; rd_addr = ra; wr_sel_n = ws_n; wr_addr = wa;
    wr_data = d0; wr_be_n = b0;
    if (!ws_n) begin
      ref_mem[{wa, 1'b0}] = masked(ref_mem[{wa, 1'b0}], d0, b0);
      ref_mem[{wa, 1'b1}] = masked(ref_mem[{wa, 1'b1}], d1, b1);
    end
    if (!rs_n) begin
      exp_v[(c + 4) % 16] = 1'b1; exp_d[(c + 4) % 16] = ref_mem[{ra, 1'b0}];
      exp_tag[(c + 4) % 16] = {tag, " R4 word0"};
      exp_v[(c + 5) % 16] = 1'b1; exp_d[(c + 5) % 16] = ref_mem[{ra, 1'b1}];
      exp_tag[(c + 5) % 16] = {tag, " R3 word1"};
    end
    @(negedge clk);
    // Second phase: selects and addresses here must be ignored (R7).
    wr_data = d1; wr_be_n = b1;
    rd_sel_n = 1'($urandom); wr_sel_n = 1'($urandom);
    rd_addr = BAW'($urandom); wr_addr = BAW'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc(1'b1, BAW'($urandom), 1'b1, BAW'($urandom), $urandom, NB'($urandom),
          $urandom, NB'($urandom), "R7");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R10"; end
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", DW'(rd_valid), DW'(0));
    check("R1 data", rd_data, '0);
    check("R1 phase", DW'(beat_ph), DW'(0));
    rst_n = 1'b1;
    running = 1'b1;
    check("R1 after release", DW'(beat_ph), DW'(0));

    // Fill every burst with full-width writes (R5).
    for (int a = 0; a < (1 << BAW); a++)
      cyc(1'b1, '0, 1'b0, BAW'(a), 32'hA000_0000 + a, '0, 32'hB000_0000 + a, '0, "R5");
    cyc(1'b0, 4'd3, 1'b1, '0, '0, '1, '0, '1, "R5");
    // Masks differing between beats (R6).
    cyc(1'b1, '0, 1'b0, 4'd5, 32'h1122_3344, 4'b1010, 32'h5566_7788, 4'b0101, "R6");
    cyc(1'b0, 4'd5, 1'b1, '0, '0, '1, '0, '1, "R6");
    // Same-cycle read and write to one burst (R8).
    cyc(1'b0, 4'd7, 1'b0, 4'd7, 32'hDEAD_0007, '0, 32'hBEEF_0007, 4'b0011, "R8");
    // Read, then a later write to that burst is not visible (R8).
    cyc(1'b0, 4'd9, 1'b1, '0, '0, '1, '0, '1, "R8");
    cyc(1'b1, '0, 1'b0, 4'd9, 32'h0909_0909, '0, 32'h9090_9090, '0, "R8");
    idle(3);
    // Back-to-back reads (R9).
    for (int a = 1; a < 5; a++) cyc(1'b0, BAW'(a), 1'b1, '0, '0, '1, '0, '1, "R9");
    // Idle with junk, then read back untouched bursts (R7).
    idle(4);
    cyc(1'b0, 4'd9, 1'b1, '0, '0, '1, '0, '1, "R7");
    cyc(1'b0, 4'd0, 1'b1, '0, '0, '1, '0, '1, "R7");
    // Random mix of both ports.
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom), BAW'($urandom), 1'($urandom), BAW'($urandom),
          $urandom, NB'($urandom), $urandom, NB'($urandom), "R3");
    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule